// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers a set of internal event lines and turns them into one shared, active-low interrupt request. A rising edge on any event line latches a pending bit for that source. Each source has its own enable bit, and only pending sources that are also enabled can raise the request. Software clears a pending bit by writing a one to it. The request level is registered and refreshed only once every 32 reference clocks, so the pin cannot glitch between refresh points.

The output behaves like an open-drain pin. It either pulls the shared line low or releases it, so the requests of several devices can be tied together. The pin is held released whenever the management interface is switched off. A small register interface gives access to the enables, to the pending bits and to a status register that shows the raw request level. A vector register answers with the register address assigned to the most urgent enabled pending source, so one read is enough to find the cause of an interrupt.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the enables and pending bits are 0, `irq_n_o` is 1 (released), and a read of the vector address 0xF8 returns 0x00.
- R2: Address 0x00 is the enable register. Bit i enables source i. A write stores the data and a read returns it.
- R3: A 0-to-1 change on `evt_i[i]` sets pending bit i whatever the enable bit holds. A level that stays high does not set the bit again after it has been cleared. Address 0x01 reads the pending bits.
- R4: A write to address 0x01 clears every pending bit whose data bit is 1. Pending bits whose data bit is 0 are left unchanged.
- R5: When a rising edge and a clear of the same source land in the same cycle, the pending bit stays set.
- R6: A read of address 0xF8 returns 0x10+i, where i is the lowest-numbered source that is both pending and enabled. Source 0 has the highest priority. The read returns 0x00 when no source is both pending and enabled.
- R7: The internal request updates only on a divider tick, once every 32 clocks. The first tick falls at the 32nd clock edge after reset. At each tick the request becomes 1 exactly when some source is pending and enabled.
- R8: Bit 2 of address 0x02 reads the request level before output gating, with 1 meaning the controller is asserting. All other bits read 0. The value is valid whatever `mgmt_en_i` holds.
- R9: `irq_n_o` is 0 (pull low) exactly when the request is 1 and `mgmt_en_i` is 1. Otherwise it is 1 (released).
- R10: Any address other than 0x00, 0x01, 0x02 and 0xF8 reads 0x00. Writes to 0x02, to 0xF8 or to unused addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Event lines, one per source |
| mgmt_en_i | input | 1 | Management interface in use; enables the pin |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address for reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_n_o | output | 1 | Open-drain style request: 0 pulls low, 1 releases |

## Verification
The hardest case to reach from the ports is a rising edge that lands in exactly the same cycle as a write-one-to-clear of that source. The other hard case is a clear that arrives just before a divider tick, which decides whether the pin is released on that tick. A directed sequence lines up the edge and the clear on one clock to cover the first case. A long random run that toggles event lines and issues clears at random phases against the 32-clock tick covers both cases many times. A cycle model in the bench predicts every read and every pin level.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned ADDR_W       = 8;
  localparam int unsigned DATA_W       = 8;
  localparam logic [7:0]  ADDR_EN      = 8'h00;
  localparam logic [7:0]  ADDR_PEND    = 8'h01;
  localparam logic [7:0]  ADDR_STAT    = 8'h02;
  localparam logic [7:0]  ADDR_VEC     = 8'hF8;
  localparam logic [7:0]  SRC_BASE     = 8'h10;
  localparam int unsigned STAT_REQ_BIT = 2;
endpackage

// File: rtl/irq_tick_div.sv
module irq_tick_div #(
  parameter int unsigned DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == CNT_W'(DIV-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] rise_o,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] evt_q, pend_q;

  assign rise_o = evt_i & ~evt_q;
  assign pend_o = pend_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        evt_q[g]  <= 1'b0;
        pend_q[g] <= 1'b0;
      end else begin
        evt_q[g] <= evt_i[g];
        // set wins over a same-cycle clear
        if (rise_o[g])     pend_q[g] <= 1'b1;
        else if (clr_i[g]) pend_q[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               any_o,
  output logic [ADDR_W-1:0]  vec_o
);
  always_comb begin
    any_o = 1'b0;
    vec_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        vec_o = SRC_BASE + ADDR_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DIV     = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               mgmt_en_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_n_o
);
  logic [NUM_SRC-1:0] en_q, pend, rise, clr, active;
  logic               tick, any_act, req_q;
  logic [ADDR_W-1:0]  vec;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i;

  assign clr    = (wr_en_i && addr_i == ADDR_PEND) ? wdata_i[NUM_SRC-1:0] : '0;
  assign active = pend & en_q;

  irq_tick_div #(.DIV(DIV)) div_i (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  irq_pend_bank #(.NUM_SRC(NUM_SRC)) bank_i (
    .clk_i (clk_i), .rst_ni(rst_ni), .evt_i(evt_i),
    .clr_i (clr),   .rise_o(rise),   .pend_o(pend)
  );

  irq_prio_enc #(.NUM_SRC(NUM_SRC)) enc_i (
    .req_i(active), .any_o(any_act), .vec_o(vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      req_q <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == ADDR_EN) en_q <= wdata_i[NUM_SRC-1:0];
      if (tick) req_q <= any_act;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_EN:   rdata_o[NUM_SRC-1:0] = en_q;
      ADDR_PEND: rdata_o[NUM_SRC-1:0] = pend;
      ADDR_STAT: rdata_o[STAT_REQ_BIT] = req_q;
      ADDR_VEC:  rdata_o = DATA_W'(vec);
      default:   rdata_o = '0;
    endcase
  end

  // released unless the management interface is in use
  assign irq_n_o = ~(req_q & mgmt_en_i);
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] rise_i,
  input logic [NUM_SRC-1:0] pend_i,
  input logic [NUM_SRC-1:0] en_i,
  input logic               tick_i,
  input logic               req_i,
  input logic               mgmt_en_i,
  input logic               irq_n_i,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_i
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r3_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ((pend_i & $past(rise_i)) == $past(rise_i)));

  a_r4_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(wr_en_i && addr_i == ADDR_PEND))
      |-> ((pend_i & $past(wdata_i[NUM_SRC-1:0] & ~rise_i)) == '0));

  a_r7_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(tick_i)) |-> $stable(req_i));

  a_r9_release_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mgmt_en_i |-> irq_n_i);

  a_r6_vec_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_VEC && (pend_i & en_i) == '0) |-> (rdata_i == '0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rise_i   (rise),
  .pend_i   (pend),
  .en_i     (en_q),
  .tick_i   (tick),
  .req_i    (req_q),
  .mgmt_en_i(mgmt_en_i),
  .irq_n_i  (irq_n_o),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_i  (rdata_o)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  localparam int N   = 8;
  localparam int DIV = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt = '0;
  logic         mgmt_en = 1'b1;
  logic         wr_en = 1'b0;
  logic [7:0]   addr = 8'h00;
  logic [7:0]   wdata = 8'h00;
  logic [7:0]   rdata;
  logic         irq_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(N), .DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .mgmt_en_i(mgmt_en),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_n_o(irq_n)
  );

  // reference model built from the requirements
  logic [N-1:0] m_en, m_pend, m_evtq;
  logic         m_req;
  int           m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= '0; m_pend <= '0; m_evtq <= '0; m_req <= 1'b0; m_cnt <= 0;
    end else begin
      logic [N-1:0] r, c;
      r = evt & ~m_evtq;
      c = (wr_en && addr == 8'h01) ? wdata[N-1:0] : '0;
      m_pend <= (m_pend & ~c) | r;
      if (wr_en && addr == 8'h00) m_en <= wdata[N-1:0];
      if (m_cnt == DIV - 1) begin
        m_req <= |(m_pend & m_en);
        m_cnt <= 0;
      end else m_cnt <= m_cnt + 1;
      m_evtq <= evt;
    end
  end

  function automatic logic [7:0] exp_vec();
    logic [N-1:0] a = m_pend & m_en;
    for (int i = 0; i < N; i++) if (a[i]) return 8'h10 + 8'(i);
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00:   return 8'(m_en);
      8'h01:   return 8'(m_pend);
      8'h02:   return {5'b0, m_req, 2'b0};
      8'hF8:   return exp_vec();
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    case (a)
      8'h00:   return "R2 enable read";
      8'h01:   return "R3/R4 pending read";
      8'h02:   return "R8 status read";
      8'hF8:   return "R6 vector read";
      default: return "R10 unused read";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_all();
    check(rd_tag(addr), rdata, exp_rd(addr));
    check("R7/R9 irq pin", {7'b0, irq_n}, {7'b0, ~(m_req & mgmt_en)});
  endtask

  // drive at negedge, check 1 ns later
  task automatic cyc(input logic [N-1:0] e, input logic we, input logic [7:0] a,
                     input logic [7:0] d, input logic me);
    @(negedge clk);
    evt = e; wr_en = we; addr = a; wdata = d; mgmt_en = me;
    #1 check_all();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    addr = 8'hF8; #1;
    check("R1 vector after reset", rdata, 8'h00);
    check("R1 irq released in reset", {7'b0, irq_n}, 8'h01);
    @(negedge clk); rst_n = 1'b1;
    addr = 8'h00; #1 check("R1 enable reset", rdata, 8'h00);
    addr = 8'h01; #1 check("R1 pending reset", rdata, 8'h00);

    // R2 enable write / readback
    cyc('0, 1'b1, 8'h00, 8'hA5, 1'b1);
    cyc('0, 1'b0, 8'h00, 8'h00, 1'b1);
    check("R2 enable readback", rdata, 8'hA5);
    // R3 edge on disabled source 1 still latches
    cyc(8'h02, 1'b0, 8'h01, 8'h00, 1'b1);
    cyc(8'h02, 1'b0, 8'h01, 8'h00, 1'b1);
    check("R3 disabled source latched", rdata, 8'h02);
    cyc(8'h02, 1'b0, 8'hF8, 8'h00, 1'b1);
    check("R6 vector none enabled", rdata, 8'h00);
    // R4 clear while level held: must not re-set
    cyc(8'h02, 1'b1, 8'h01, 8'h02, 1'b1);
    cyc(8'h02, 1'b0, 8'h01, 8'h00, 1'b1);
    check("R3/R4 held level no reset", rdata, 8'h00);
    // R5 rise and clear same cycle on source 2 (enabled)
    cyc(8'h00, 1'b0, 8'h01, 8'h00, 1'b1);
    cyc(8'h04, 1'b1, 8'h01, 8'h04, 1'b1);
    cyc(8'h04, 1'b0, 8'h01, 8'h00, 1'b1);
    check("R5 set wins over clear", rdata, 8'h04);
    // R6 priority: sources 2 and 5 pending, both enabled
    cyc(8'h24, 1'b0, 8'hF8, 8'h00, 1'b1);
    cyc(8'h24, 1'b0, 8'hF8, 8'h00, 1'b1);
    check("R6 lowest index wins", rdata, 8'h12);
    // R10 write to vector/unused ignored
    cyc(8'h24, 1'b1, 8'hF8, 8'hFF, 1'b1);
    cyc(8'h24, 1'b1, 8'h55, 8'hFF, 1'b1);
    cyc(8'h24, 1'b0, 8'h00, 8'h00, 1'b1);
    check("R10 enable untouched", rdata, 8'hA5);
    // R9 pin released while management off, across ticks
    for (int k = 0; k < 2 * DIV; k++) cyc(8'h24, 1'b0, 8'h02, 8'h00, 1'b0);
    check("R8 raw level while off", rdata, 8'h04);
    check("R9 released while off", {7'b0, irq_n}, 8'h01);

    // random phase
    for (int k = 0; k < 6000; k++) begin
      logic [N-1:0] e = evt;
      logic         we = 1'b0;
      logic [7:0]   a, d;
      logic         me = mgmt_en;
      if ($urandom % 3 == 0) e = e ^ N'(1 << ($urandom % N));
      case ($urandom % 6)
        0: a = 8'h00; 1: a = 8'h01; 2: a = 8'h02;
        3, 4: a = 8'hF8; default: a = 8'($urandom % 256);
      endcase
      d = 8'($urandom);
      if ($urandom % 8 == 0) we = 1'b1;
      if (we && $urandom % 2 == 0) a = 8'h01;
      if ($urandom % 200 == 0) me = ~me;
      cyc(e, we, a, d, me);
    end
    wr_en = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule